// File: doc/BRIEF.md
# Byte-Banked Interrupt Aggregator

This block gathers a set of interrupt request lines, by default 24, into byte-wide banks and merges them into one interrupt line for a host that triggers on rising edges. Most sources are edge-captured. After a two-flop synchronizer, a rising transition of an enabled source sets a sticky status bit. One source, chosen by parameter, is treated as a level: its status bit always shows the synchronized input. Each bank has a status byte and a mask byte on a small byte-wide register bus.

The host reads a status byte to find out which sources fired. That same read acknowledges the edge-captured bits of the bank, so no write-to-clear register exists. The host enables or disables individual sources by read-modify-write of the mask bytes. A mask bit of 1 enables its source. The combined output is registered, and it is forced low for one cycle after every status read taken while it is high. Events still pending, or arriving after the acknowledge, therefore always produce a fresh rising edge.

The register bus is a plain single-cycle strobe interface with no valid/ready back-pressure. A transfer happens in every cycle where `bus_sel` is high, and it is always accepted. Read data is combinational in that same cycle. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `irq_byte_agg`

## Requirements
- R1: After reset every mask byte reads 0x00, every status byte reads 0x00 (while no level input is high), `pend_vec` is 0 and `irq_out` is 0.
- R2: The mask bytes sit at addresses 3 (bits 7:0), 4 (bits 15:8) and 5 (bits 23:16). A write stores the byte, and a read returns the stored byte. A mask bit of 1 enables its source.
- R3: A 0-to-1 transition of an enabled edge source sets its status bit. The bit stays set after the input falls. The status bytes are read at address 0 (bits 7:0), address 1 (bits 15:8) and address 2 (bits 23:16).
- R4: A rising transition that occurs while the source's mask bit is 0 is discarded. No status bit is set, `pend_vec` and `irq_out` stay low, and enabling the mask later does not bring the event back.
- R5: `pend_vec` equals status AND mask. Bank 0 occupies bits 7:0, bank 1 bits 15:8 and bank 2 bits 23:16.
- R6: A status read returns the value held before the read. It then clears the edge-captured bits of that bank only, and other banks are unchanged.
- R7: A rising transition captured in the same cycle as a status read of its bank is kept and appears on the next read.
- R8: The level source (index LEVEL_SRC, default 13, which is bit 5 of address 1) shows the synchronized live input in its status bit regardless of its mask. A status read does not clear it.
- R9: `irq_out` rises the cycle after `pend_vec` becomes non-zero, and it falls once `pend_vec` is zero.
- R10: A status read performed while `irq_out` is high forces `irq_out` low for the following cycle. If sources are still pending, it rises again one cycle later.
- R11: Writes to status addresses 0 to 2 have no effect. Addresses 6 and 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 24 | Raw interrupt requests, asynchronous |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is strobed |
| pend_vec | output | 24 | Status AND mask, all banks |
| irq_out | output | 1 | Combined interrupt toward the host |

## Verification
The main function is tried with single pulses on enabled sources in each bank, pulses on masked sources, and a held level on the level source. These patterns separate sticky edge capture from discard-while-masked and from live level reporting. A multi-bank pattern with mixed masks checks the bank order of the pending vector and shows that an acknowledge touches only its own bank. A pulse timed so that its capture cycle lands on a status read of its bank checks that no edge is lost. A status read under a held level checks the forced low cycle and the following re-assertion.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Per-bank strobes decoded from the register bus.
  typedef struct packed {
    logic stat_rd;
    logic mask_wr;
  } bank_ctl_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~prev_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_agg_pkg::*;
#(
  parameter int W         = 8,
  parameter bit HAS_LEVEL = 1'b0,
  parameter int LEVEL_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise,
  input  bank_ctl_t    ctl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic [W-1:0] pend
);
  localparam logic [W-1:0] LVL_SEL  = HAS_LEVEL ? (W'(1) << LEVEL_BIT) : '0;
  localparam logic [W-1:0] EDGE_SEL = ~LVL_SEL;

  logic [W-1:0] cap_q, mask_q, cap_d;

  // Clear-on-read, with a coincident edge taking precedence.
  always_comb begin
    cap_d = ctl.stat_rd ? '0 : cap_q;
    cap_d = cap_d | (rise & mask_q & EDGE_SEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      mask_q <= '0;
    end else begin
      cap_q <= cap_d;
      if (ctl.mask_wr) mask_q <= wdata;
    end
  end

  assign status = (cap_q & EDGE_SEL) | (lvl & LVL_SEL);
  assign mask   = mask_q;
  assign pend   = status & mask_q;

  // R4
  masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cap_q & ~$past(cap_q) & ~$past(mask_q) & EDGE_SEL) == '0));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stat_rd |=> ((cap_q & ~$past(rise)) == '0));

  // R7
  coincident_edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stat_rd |=> ((cap_q & $past(rise & mask_q & EDGE_SEL)) == $past(rise & mask_q & EDGE_SEL)));

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic ack,
  output logic irq_out
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend & ~(irq_q & ack);
  end

  assign irq_out = irq_q;

  // R10
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && ack) |=> !irq_q);

  // R9
  out_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(any_pend));
endmodule

// File: rtl/irq_byte_agg.sv
module irq_byte_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int LEVEL_SRC = 13,
  parameter int NSRC      = NUM_BANKS * BANK_W,
  parameter int AW        = $clog2(2 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic [NSRC-1:0]   pend_vec,
  output logic              irq_out
);
  logic [NSRC-1:0]   lvl_all, rise_all;
  logic [BANK_W-1:0] stat_b [NUM_BANKS];
  logic [BANK_W-1:0] mask_b [NUM_BANKS];
  bank_ctl_t         ctl_b  [NUM_BANKS];
  logic [NUM_BANKS-1:0] rd_hit;

  irq_edge_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .lvl(lvl_all), .rise(rise_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      ctl_b[b].stat_rd = bus_sel && !bus_wr && (bus_addr == AW'(b));
      ctl_b[b].mask_wr = bus_sel &&  bus_wr && (bus_addr == AW'(NUM_BANKS + b));
    end
    assign rd_hit[b] = ctl_b[b].stat_rd;

    irq_bank #(
      .W(BANK_W),
      .HAS_LEVEL((LEVEL_SRC / BANK_W) == b),
      .LEVEL_BIT(LEVEL_SRC % BANK_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lvl(lvl_all[b*BANK_W +: BANK_W]),
      .rise(rise_all[b*BANK_W +: BANK_W]),
      .ctl(ctl_b[b]),
      .wdata(bus_wdata),
      .status(stat_b[b]),
      .mask(mask_b[b]),
      .pend(pend_vec[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == AW'(b))             bus_rdata = stat_b[b];
      if (bus_addr == AW'(NUM_BANKS + b)) bus_rdata = mask_b[b];
    end
  end

  irq_out_gen u_out (
    .clk(clk), .rst_n(rst_n),
    .any_pend(|pend_vec),
    .ack(|rd_hit),
    .irq_out(irq_out)
  );

  // R6
  one_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit));
endmodule

// File: tb/test_irq_byte_agg.sv
module test_irq_byte_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] pend_vec;
  logic        irq_out;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_byte_agg i_irq_byte_agg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_vec(pend_vec), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the access edge.
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int src);
    irq_in[src] = 1'b1; idle(4);
    irq_in[src] = 1'b0; idle(4);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d); chk("R1 reg reset", d, 0);
    end
    chk("R1 pend reset", pend_vec, 0);
    chk("R1 irq reset", irq_out, 0);
  endtask

  task automatic t_mask_rw();
    logic [7:0] d;
    wr(3, 8'hA5); wr(4, 8'h3C); wr(5, 8'h81);
    rd(3, d); chk("R2 mask lo", d, 8'hA5);
    rd(4, d); chk("R2 mask hi", d, 8'h3C);
    rd(5, d); chk("R2 mask third", d, 8'h81);
    wr(3, 0); wr(4, 0); wr(5, 0);
  endtask

  task automatic t_masked_drop();
    logic [7:0] d;
    pulse(2); idle(2);
    rd(0, d); chk("R4 status after masked edge", d, 0);
    chk("R4 pend", pend_vec, 0);
    chk("R4 irq", irq_out, 0);
    wr(3, 8'h04); idle(6);
    rd(0, d); chk("R4 not revived by unmask", d, 0);
    chk("R4 irq after unmask", irq_out, 0);
    wr(3, 0);
  endtask

  task automatic t_capture_pend();
    logic [7:0] d;
    wr(3, 8'h81); wr(4, 8'h01); wr(5, 8'h80);
    pulse(0); pulse(1); pulse(8); pulse(23); idle(2);
    chk("R3 R5 pend vector", pend_vec, 24'h800101);
    chk("R9 irq high", irq_out, 1);
    wr(4, 8'h00); idle(1);
    chk("R5 mask gates pend", pend_vec, 24'h800001);
    rd(0, d); chk("R3 R6 lo status pre-clear", d, 8'h01);
    chk("R6 only lo cleared", pend_vec, 24'h800000);
    rd(1, d); chk("R6 hi status kept", d, 8'h01);
    rd(2, d); chk("R6 third status kept", d, 8'h80);
    idle(3);
    chk("R9 irq low when nothing pending", irq_out, 0);
    rd(0, d); chk("R6 lo reads empty", d, 0);
    wr(3, 0); wr(5, 0);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(5, 8'h03);
    pulse(16); idle(2);
    irq_in[17] = 1'b1;   // e1 sync1, e2 sync2 -> rise, e3 capture
    idle(2);             // now between e2 and e3
    rd(2, d); chk("R7 read before capture", d, 8'h01);
    rd(2, d); chk("R7 coincident edge kept", d, 8'h02);
    rd(2, d); chk("R7 cleared afterwards", d, 0);
    irq_in[17] = 1'b0; idle(4);
    wr(5, 0);
  endtask

  task automatic t_level_gap();
    logic [7:0] d;
    irq_in[13] = 1'b1; idle(5);
    rd(1, d); chk("R8 live level masked off", d, 8'h20);
    rd(1, d); chk("R8 not cleared by read", d, 8'h20);
    chk("R8 no pend while masked", pend_vec, 0);
    wr(4, 8'h20); idle(3);
    chk("R9 irq from level", irq_out, 1);
    rd(1, d);
    chk("R10 forced low after read", irq_out, 0);
    idle(1);
    chk("R10 reasserts", irq_out, 1);
    irq_in[13] = 1'b0; idle(5);
    rd(1, d); chk("R8 level follows input", d, 0);
    chk("R9 irq drops", irq_out, 0);
    wr(4, 0);
  endtask

  task automatic t_status_write();
    logic [7:0] d;
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF);
    rd(0, d); chk("R11 status write ignored lo", d, 0);
    rd(2, d); chk("R11 status write ignored third", d, 0);
    rd(3, d); chk("R11 mask untouched", d, 0);
    rd(6, d); chk("R11 addr 6", d, 0);
    rd(7, d); chk("R11 addr 7", d, 0);
    chk("R11 no pend", pend_vec, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_mask_rw();
    t_masked_drop();
    t_capture_pend();
    t_collision();
    t_level_gap();
    t_status_write();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule